// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N synthesizer loop. It runs on the oscillator-side input clock and produces one short feedback pulse per programmed number of input cycles. In its normal mode, a prescaler model switches between dividing by eleven and by ten. A 9-bit main count sets how many prescaler periods make up one output period. A 4-bit swallow count sets how many of those periods use the longer modulus. The total ratio is ten times (main + 1) plus swallow. The modulus-select level is exported so that a debug pin can observe it.

In bypass mode the prescaler and the swallow counter stay idle, and the main counter alone divides the input clock by main + 1. New settings are normally picked up when a period ends, so a running period is never cut short. A reload strobe applies them at once and restarts the count. Power-down clears the counting state and keeps both outputs low. The prescaler is modelled as synchronous logic on the input clock.

Top module: `pswal_div`

## Requirements
- R1: With `byp_en` low, consecutive `fp` pulses are exactly 10·(M+1)+A input clock cycles apart, where M is `m_val` (legal range 1 to 511) and A is `a_val` with A ≤ M+1.
- R2: With `byp_en` low, `msel` (high means divide by 11) is high for exactly 11·A input clocks in every output period. All values of A from 0 to 15 are accepted, including A = M+1, where every prescaler period is the long one.
- R3: With `byp_en` high, consecutive `fp` pulses are M+1 input clocks apart, `a_val` has no effect, and `msel` stays low.
- R4: `fp` is high for exactly one input clock per output period.
- R5: A change on `m_val`, `a_val` or `byp_en` without `load_now` does not shorten or lengthen the running period. It takes effect from the next period on.
- R6: When `load_now` is sampled high at a clock edge, the counters restart from the current inputs and `fp` stays low in the following cycle. The next `fp` rises N clock edges after the last edge that samples `load_now` high, where N is the ratio of the new settings. While `load_now` is held high, `fp` never rises.
- R7: From the first edge that samples `pwr_dn` high, `fp` and `msel` stay low. After `pwr_dn` is sampled low again, the first `fp` rises N edges after that first low sample.
- R8: While `rst_n` is low, `fp` and `msel` are low. After reset is released, the first `fp` rises N edges after the first clock edge.
- R9: The minimum main setting M = 1 gives a main ratio of 2, so M = 1, A = 0 divides by 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from the oscillator side |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Synchronous power-down; clears the counting state |
| byp_en | input | 1 | High selects bypass (main counter only) |
| m_val | input | 9 | Main count setting M |
| a_val | input | 4 | Swallow count setting A |
| load_now | input | 1 | Reload strobe that restarts the count at once |
| fp | output | 1 | Divided feedback pulse, one clock wide |
| msel | output | 1 | Modulus select, high while the prescaler divides by 11 |

## Verification
The bound checker checks the following on every cycle:
- `fp` is never high two cycles in a row.
- A sampled reload strobe or power-down suppresses `fp` in the next cycle.
- Power-down also clears `msel` in the next cycle.
- A reload into bypass drops `msel`.
- The mode bit cannot change except at a period boundary or a reload.

The exact pulse spacing and the number of long-modulus cycles per period cannot be checked cycle by cycle. Only the bench's scenarios show them. The bench times the intervals between pulses across several M/A pairs and both modes. It also times when settings changed mid-period take effect, and the startup latency after reset and after power-down.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    // Main counter width (M field)
    localparam int unsigned M_W    = 9;
    // Swallow counter width (A field)
    localparam int unsigned A_W    = 4;
    // Short modulus of the dual-modulus prescaler
    localparam int unsigned PRE_LO = 10;
    // Long modulus is one more than the short one
    localparam int unsigned PRE_HI = PRE_LO + 1;
    // Prescaler down-counter width, holds PRE_HI-1
    localparam int unsigned PC_W   = $clog2(PRE_HI);

    typedef struct packed {
        logic           byp;
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
    } div_cfg_t;

endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
    import pswal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    input  logic restart,
    input  logic byp_cur,
    input  logic byp_new,
    input  logic mod11_next,
    output logic tick
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       byp_sel;

    always_comb begin
        st_d    = st_q;
        // in bypass every input clock is one prescaler period
        tick    = byp_cur || (st_q.pc == '0);
        byp_sel = restart ? byp_new : byp_cur;
        if (off) begin
            st_d.pc = '0;
        end else if (restart || tick) begin
            if (byp_sel) begin
                st_d.pc = '0;
            end else if (mod11_next) begin
                st_d.pc = PC_W'(PRE_HI - 1);
            end else begin
                st_d.pc = PC_W'(PRE_LO - 1);
            end
        end else begin
            st_d.pc = st_q.pc - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pswal_counters.sv
module pswal_counters
    import pswal_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     off,
    input  logic     restart,
    input  logic     tick,
    input  logic     byp_cur,
    input  div_cfg_t load_cfg,
    output logic     mc_zero,
    output logic     swallow_live,
    output logic     mod11_next
);

    typedef struct packed {
        logic [M_W-1:0] mc;
        logic [A_W-1:0] ac;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        mc_zero      = (st_q.mc == '0);
        swallow_live = !byp_cur && (st_q.ac != '0);
        if (off) begin
            st_d = '0;
        end else if (restart) begin
            st_d.mc = load_cfg.m;
            st_d.ac = load_cfg.byp ? '0 : load_cfg.a;
        end else if (tick) begin
            st_d.mc = st_q.mc - 1'b1;
            if (st_q.ac != '0) begin
                st_d.ac = st_q.ac - 1'b1;
            end
        end
        // modulus for the prescaler period that starts next
        mod11_next = (st_d.ac != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pswal_div.sv
module pswal_div
    import pswal_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_dn,
    input  logic           byp_en,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic           load_now,
    output logic           fp,
    output logic           msel
);

    typedef struct packed {
        logic run;
        logic byp;
        logic fp;
    } top_state_t;

    top_state_t st_d, st_q;
    div_cfg_t   cfg_new;
    logic       run_q, byp_q;
    logic       tick, mc_zero, swallow_live, mod11_next;
    logic       terminal, restart;

    assign run_q = st_q.run;
    assign byp_q = st_q.byp;

    always_comb begin
        cfg_new.byp = byp_en;
        cfg_new.a   = a_val;
        cfg_new.m   = m_val;
        terminal    = run_q && tick && mc_zero;
        restart     = !run_q || load_now || terminal;
        st_d        = st_q;
        st_d.run    = !pwr_dn;
        if (pwr_dn) begin
            st_d.byp = 1'b0;
            st_d.fp  = 1'b0;
        end else begin
            if (restart) begin
                st_d.byp = byp_en;
            end
            st_d.fp = terminal && !load_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pswal_prescaler i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .off        (pwr_dn),
        .restart    (restart),
        .byp_cur    (byp_q),
        .byp_new    (byp_en),
        .mod11_next (mod11_next),
        .tick       (tick)
    );

    pswal_counters i_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .off          (pwr_dn),
        .restart      (restart),
        .tick         (tick),
        .byp_cur      (byp_q),
        .load_cfg     (cfg_new),
        .mc_zero      (mc_zero),
        .swallow_live (swallow_live),
        .mod11_next   (mod11_next)
    );

    assign fp   = st_q.fp;
    assign msel = run_q && swallow_live;

endmodule

// File: rtl/pswal_div_chk.sv
module pswal_div_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn,
    input logic byp_en,
    input logic load_now,
    input logic fp,
    input logic msel,
    input logic run_q,
    input logic byp_q,
    input logic terminal
);

    // R4
    fp_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R7
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!fp && !msel));

    // R6
    load_no_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> !fp);

    // R3
    byp_no_msel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && byp_en && !pwr_dn) |=> !msel);

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !pwr_dn && !load_now && !terminal) |=> $stable(byp_q));

endmodule

bind pswal_div pswal_div_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .byp_en   (byp_en),
    .load_now (load_now),
    .fp       (fp),
    .msel     (msel),
    .run_q    (run_q),
    .byp_q    (byp_q),
    .terminal (terminal)
);

// File: tb/test_pswal_div.sv
module test_pswal_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       byp_en = 1'b0;
    logic       load_now = 1'b0;
    logic [8:0] m_val = 9'd4;
    logic [3:0] a_val = 4'd3;
    logic       fp, msel;

    typedef struct {
        int    per;
        int    ms;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   bad = 0;

    always #10 clk = ~clk;

    pswal_div i_pswal_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .byp_en   (byp_en),
        .m_val    (m_val),
        .a_val    (a_val),
        .load_now (load_now),
        .fp       (fp),
        .msel     (msel)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int ratio(input int m, input int a, input bit b);
        return b ? (m + 1) : (10 * (m + 1) + a);
    endfunction

    function automatic int long_cycles(input int a, input bit b);
        return b ? 0 : 11 * a;
    endfunction

    task automatic push(input int per, input int ms, input string tag);
        exp_t e;
        e.per = per;
        e.ms  = ms;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_fp();
        do @(negedge clk); while (!fp);
        #1;
    endtask

    task automatic run_cfg(input int m, input int a, input bit b,
                           input int n, input string tag);
        @(negedge clk);
        #1;
        m_val  = 9'(m);
        a_val  = 4'(a);
        byp_en = b;
        push(0, -1, tag);
        for (int i = 0; i < n; i++) push(ratio(m, a, b), long_cycles(a, b), tag);
        drain();
    endtask

    // monitor: measures pulse spacing and long-modulus cycles, pops expectations
    initial begin
        int   cnt;
        int   ms;
        bit   have;
        bit   last_fp;
        exp_t e;
        cnt = 0; ms = 0; have = 0; last_fp = 0;
        forever begin
            @(negedge clk);
            if (last_fp) chk(fp == 1'b0, "R4", "fp width", int'(fp), 0);
            last_fp = fp;
            if (!rst_n || pwr_dn) begin
                have = 0; cnt = 0; ms = 0;
            end else begin
                cnt++;
                if (msel) ms++;
                if (fp) begin
                    if (have && exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        if (e.per != 0) chk(cnt == e.per, e.tag, "period", cnt, e.per);
                        if (e.ms >= 0) chk(ms == e.ms, e.tag, "msel cycles", ms, e.ms);
                    end
                    have = 1; cnt = 0; ms = 0;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL R1 watchdog expired: got %0d expected %0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int n;
        // R8: outputs low in reset
        repeat (3) begin
            @(negedge clk);
            chk(fp == 1'b0 && msel == 1'b0, "R8", "outputs in reset",
                int'({fp, msel}), 0);
        end
        #1 rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!fp && n < 1000);
        chk(n == 54, "R8", "first pulse after reset", n, 54);

        run_cfg(4, 3, 1'b0, 2, "R1");
        run_cfg(1, 0, 1'b0, 3, "R9");
        run_cfg(1, 2, 1'b0, 3, "R2");
        run_cfg(14, 15, 1'b0, 2, "R2");
        run_cfg(37, 6, 1'b0, 2, "R1");
        run_cfg(1, 0, 1'b1, 4, "R3");
        run_cfg(9, 5, 1'b1, 3, "R3");
        run_cfg(511, 0, 1'b1, 2, "R3");
        run_cfg(511, 15, 1'b0, 2, "R1");
        run_cfg(6, 4, 1'b0, 2, "R1");

        // R5: change mid-period, running period keeps 74
        wait_fp();
        push(74, -1, "R5");
        push(31, 11, "R5");
        repeat (5) @(negedge clk);
        #1;
        m_val = 9'd2;
        a_val = 4'd1;
        drain();

        // R6: single-cycle reload strobe to M=8, A=9 (ratio 99)
        wait_fp();
        push(100, -1, "R6");
        push(99, 99, "R6");
        m_val = 9'd8;
        a_val = 4'd9;
        load_now = 1'b1;
        @(negedge clk);
        #1 load_now = 1'b0;
        drain();

        // R6: held strobe, no pulses, then M=3, A=4 (ratio 44)
        wait_fp();
        push(64, -1, "R6");
        push(44, 44, "R6");
        m_val = 9'd3;
        a_val = 4'd4;
        load_now = 1'b1;
        repeat (20) begin
            @(negedge clk);
            chk(fp == 1'b0, "R6", "fp while reload held", int'(fp), 0);
        end
        #1 load_now = 1'b0;
        drain();

        // R7: power-down while a long-modulus period runs
        wait_fp();
        pwr_dn = 1'b1;
        m_val = 9'd5;
        a_val = 4'd2;
        repeat (20) begin
            @(negedge clk);
            chk(fp == 1'b0 && msel == 1'b0, "R7", "outputs in power-down",
                int'({fp, msel}), 0);
        end
        #1 pwr_dn = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!fp && n < 1000);
        chk(n == 63, "R7", "first pulse after power-down", n, 63);
        run_cfg(5, 2, 1'b0, 2, "R7");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule